// File: doc/BRIEF.md
# Data Memory Address Generator

This block forms the effective data-memory address for the load and store operations of a small 8-bit processor. It also produces the updated value of the chosen 16-bit pointer register pair. A request carries the following fields:

- an addressing mode
- a load/store flag
- a 7-bit address field taken from the instruction
- a pointer select
- the store data

The current X, Y and Z pointer values come in as plain 16-bit buses from the register file.

The block checks the computed address against a set of read-only ranges. Lock bits and flash are mapped into these ranges, and a store that lands in one of them is dropped and flagged. Each accepted request then runs a fixed two-cycle sequence. In the first cycle the address is computed and registered. In the second cycle the SRAM strobe is driven, together with the pointer write-back strobe.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold every request field and pointer bus stable. `req_ready` is low for exactly the one access cycle that follows each acceptance. The SRAM side and the pointer write-back are plain strobes with no back-pressure.

Top module: `dmem_agu`

## Requirements
- R1: Mode code 2'b00 (direct) yields the address 0x0040 plus the 7-bit field. Field 0 gives 0x0040 and field 127 gives 0x00BF. No pointer write-back happens in this mode.
- R2: Mode code 2'b01 (plain indirect) uses the selected pointer unchanged as the address, with no write-back. Pointer select 2'b00 picks X, 2'b01 picks Y, and both 2'b10 and 2'b11 pick Z. `ptr_wb_sel` reports the normalised select, which is 2 for Z.
- R3: Mode code 2'b10 (pre-decrement) uses the pointer minus one as the address. It writes the same value back to the selected pointer.
- R4: Mode code 2'b11 (post-increment) uses the unchanged pointer as the address. It writes the pointer plus one back.
- R5: Pointer arithmetic wraps modulo 2^16. Pre-decrement of 0x0000 gives 0xFFFF, and post-increment of 0xFFFF gives 0x0000.
- R6: The access strobes appear only in the cycle right after the accepting edge. They last exactly one cycle, with `req_ready` low during that cycle. These strobes are `mem_rd` for a load, `mem_wr` or `ro_viol` for a store, and `ptr_wb_en` where the mode requires it. `mem_addr` and `mem_wdata` are valid during that same cycle.
- R7: The default read-only ranges are 0x3F00–0x3F03 and 0x4000–0x7FFF, both inclusive. A store whose address falls in either range drives `ro_viol` high for one cycle and leaves `mem_wr` low. The pointer write-back still happens. A load from those ranges is an ordinary read. Addresses just outside a range (0x3EFF, 0x3F04, 0x3FFF, 0x8000) are writable.
- R8: Out of reset and whenever no request has been accepted, `req_ready` is high and `mem_rd`, `mem_wr`, `ro_viol` and `ptr_wb_en` are low. A request presented while `req_ready` is low is accepted once, on the first edge where ready is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_mode | input | 2 | 00 direct, 01 indirect, 10 pre-decrement, 11 post-increment |
| req_store | input | 1 | 1 store, 0 load |
| req_field | input | 7 | Direct address field from the instruction |
| req_ptr_sel | input | 2 | 00 X, 01 Y, 10/11 Z |
| req_wdata | input | 8 | Store data |
| ptr_x | input | 16 | Current X pointer (R27:R26) |
| ptr_y | input | 16 | Current Y pointer (R29:R28) |
| ptr_z | input | 16 | Current Z pointer (R31:R30) |
| mem_addr | output | 16 | Effective address, valid in the access cycle |
| mem_rd | output | 1 | SRAM read strobe |
| mem_wr | output | 1 | SRAM write strobe |
| mem_wdata | output | 8 | Store data toward the SRAM |
| ro_viol | output | 1 | Store to a read-only range was suppressed |
| ptr_wb_en | output | 1 | Pointer write-back strobe |
| ptr_wb_sel | output | 2 | Pointer being written back (0 X, 1 Y, 2 Z) |
| ptr_wb_val | output | 16 | New pointer value |

## Verification
The hardest case to reach from the ports is a new request that arrives while the previous one is still in its access cycle. The requester sees `req_ready` low while the old pointer write-back is on the outputs, and the new fields must not leak into that access. The stimulus task chains its calls without a gap: it raises `req_valid` with the next request at the very negative edge where the previous access is under way. Every pair of consecutive requests therefore exercises the stall and the single late acceptance. The wrap values and the single-address edges of each read-only range are driven through pre-decrement and post-increment, so the boundary is crossed by the pointer arithmetic itself.

// File: rtl/dmem_agu_pkg.sv
package dmem_agu_pkg;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int FIELD_W = 7;
  localparam int SEL_W   = 2;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'b00,
    AM_INDIRECT = 2'b01,
    AM_PREDEC   = 2'b10,
    AM_POSTINC  = 2'b11
  } amode_e;

  // One accepted access, held for its second cycle
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              store;
    logic              ro;
    logic              wb_en;
    logic [SEL_W-1:0]  wb_sel;
    logic [ADDR_W-1:0] wb_val;
    logic [DATA_W-1:0] wdata;
    amode_e            mode;
  } access_t;

endpackage

// File: rtl/dmem_agu_addr.sv
module dmem_agu_addr
  import dmem_agu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DIR_BASE = 16'h0040
) (
  input  amode_e             mode,
  input  logic [FIELD_W-1:0] field,
  input  logic [SEL_W-1:0]   ptr_sel,
  input  logic [ADDR_W-1:0]  ptr_x,
  input  logic [ADDR_W-1:0]  ptr_y,
  input  logic [ADDR_W-1:0]  ptr_z,
  output logic [ADDR_W-1:0]  ea,
  output logic               wb_en,
  output logic [SEL_W-1:0]   wb_sel,
  output logic [ADDR_W-1:0]  wb_val
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] dec;
  logic [ADDR_W-1:0] inc;

  // Pointer select: codes 2 and 3 both name Z
  always_comb begin
    unique case (ptr_sel)
      2'b00:   begin base = ptr_x; wb_sel = 2'd0; end
      2'b01:   begin base = ptr_y; wb_sel = 2'd1; end
      default: begin base = ptr_z; wb_sel = 2'd2; end
    endcase
  end

  // Both neighbours computed in parallel; wrap is natural at ADDR_W bits
  assign dec = base - ADDR_W'(1);
  assign inc = base + ADDR_W'(1);

  always_comb begin
    ea     = base;
    wb_en  = 1'b0;
    wb_val = base;
    unique case (mode)
      AM_DIRECT:   ea = DIR_BASE + ADDR_W'(field);
      AM_INDIRECT: ea = base;
      AM_PREDEC:   begin ea = dec;  wb_en = 1'b1; wb_val = dec; end
      AM_POSTINC:  begin ea = base; wb_en = 1'b1; wb_val = inc; end
      default:     ea = base;
    endcase
  end

endmodule

// File: rtl/dmem_agu_ro_check.sv
module dmem_agu_ro_check
  import dmem_agu_pkg::*;
#(
  parameter int                         NUM_RO = 2,
  parameter logic [NUM_RO*ADDR_W-1:0]   RO_LO  = {16'h4000, 16'h3F00},
  parameter logic [NUM_RO*ADDR_W-1:0]   RO_HI  = {16'h7FFF, 16'h3F03}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ro_hit
);

  logic [NUM_RO-1:0] hit;

  for (genvar g = 0; g < NUM_RO; g++) begin : g_region
    localparam logic [ADDR_W-1:0] LO = RO_LO[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI = RO_HI[g*ADDR_W +: ADDR_W];
    assign hit[g] = (addr >= LO) && (addr <= HI);
  end

  assign ro_hit = |hit;

endmodule

// File: rtl/dmem_agu_seq.sv
module dmem_agu_seq
  import dmem_agu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DIR_BASE = 16'h0040
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_store,
  input  logic [DATA_W-1:0]  req_wdata,
  input  amode_e             mode,
  input  logic [ADDR_W-1:0]  ea,
  input  logic               wb_en_c,
  input  logic [SEL_W-1:0]   wb_sel_c,
  input  logic [ADDR_W-1:0]  wb_val_c,
  input  logic               ro_hit,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               ro_viol,
  output logic               ptr_wb_en,
  output logic [SEL_W-1:0]   ptr_wb_sel,
  output logic [ADDR_W-1:0]  ptr_wb_val
);

  localparam logic [ADDR_W-1:0] DIR_TOP = DIR_BASE + ADDR_W'((1 << FIELD_W) - 1);

  logic    busy;
  logic    fire;
  access_t acc_q;

  assign req_ready = ~busy;
  assign fire      = req_valid & req_ready;

  // Cycle 1: register the computed access; cycle 2: drive it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      acc_q <= '0;
    end else begin
      busy <= fire;
      if (fire) begin
        acc_q.addr   <= ea;
        acc_q.store  <= req_store;
        acc_q.ro     <= ro_hit;
        acc_q.wb_en  <= wb_en_c;
        acc_q.wb_sel <= wb_sel_c;
        acc_q.wb_val <= wb_val_c;
        acc_q.wdata  <= req_wdata;
        acc_q.mode   <= mode;
      end
    end
  end

  assign mem_addr   = acc_q.addr;
  assign mem_wdata  = acc_q.wdata;
  assign mem_rd     = busy & ~acc_q.store;
  assign mem_wr     = busy &  acc_q.store & ~acc_q.ro;
  assign ro_viol    = busy &  acc_q.store &  acc_q.ro;
  assign ptr_wb_en  = busy &  acc_q.wb_en;
  assign ptr_wb_sel = acc_q.wb_sel;
  assign ptr_wb_val = acc_q.wb_val;

  p_access_follows_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (mem_rd || mem_wr || ro_viol));

  p_access_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || ro_viol) |=> !(mem_rd || mem_wr || ro_viol));

  p_ready_low_in_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || ro_viol) |-> !req_ready);

  p_viol_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ro_viol |-> !mem_wr && !mem_rd);

  p_direct_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_q.mode == AM_DIRECT) |-> (mem_addr >= DIR_BASE && mem_addr <= DIR_TOP && !ptr_wb_en));

  p_predec_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wb_en && acc_q.mode == AM_PREDEC) |-> ptr_wb_val == mem_addr);

  p_postinc_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wb_en && acc_q.mode == AM_POSTINC) |-> ptr_wb_val == mem_addr + ADDR_W'(1));

  p_wb_needs_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wb_en |-> (mem_rd || mem_wr || ro_viol));

endmodule

// File: rtl/dmem_agu.sv
module dmem_agu
  import dmem_agu_pkg::*;
#(
  parameter logic [ADDR_W-1:0]        DIR_BASE = 16'h0040,
  parameter int                       NUM_RO   = 2,
  parameter logic [NUM_RO*ADDR_W-1:0] RO_LO    = {16'h4000, 16'h3F00},
  parameter logic [NUM_RO*ADDR_W-1:0] RO_HI    = {16'h7FFF, 16'h3F03}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_mode,
  input  logic               req_store,
  input  logic [FIELD_W-1:0] req_field,
  input  logic [SEL_W-1:0]   req_ptr_sel,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [ADDR_W-1:0]  ptr_x,
  input  logic [ADDR_W-1:0]  ptr_y,
  input  logic [ADDR_W-1:0]  ptr_z,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               ro_viol,
  output logic               ptr_wb_en,
  output logic [SEL_W-1:0]   ptr_wb_sel,
  output logic [ADDR_W-1:0]  ptr_wb_val
);

  amode_e            mode;
  logic [ADDR_W-1:0] ea;
  logic              wb_en_c;
  logic [SEL_W-1:0]  wb_sel_c;
  logic [ADDR_W-1:0] wb_val_c;
  logic              ro_hit;

  assign mode = amode_e'(req_mode);

  dmem_agu_addr #(.DIR_BASE(DIR_BASE)) u_addr (
    .mode    (mode),
    .field   (req_field),
    .ptr_sel (req_ptr_sel),
    .ptr_x   (ptr_x),
    .ptr_y   (ptr_y),
    .ptr_z   (ptr_z),
    .ea      (ea),
    .wb_en   (wb_en_c),
    .wb_sel  (wb_sel_c),
    .wb_val  (wb_val_c)
  );

  dmem_agu_ro_check #(.NUM_RO(NUM_RO), .RO_LO(RO_LO), .RO_HI(RO_HI)) u_ro (
    .addr   (ea),
    .ro_hit (ro_hit)
  );

  dmem_agu_seq #(.DIR_BASE(DIR_BASE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_store  (req_store),
    .req_wdata  (req_wdata),
    .mode       (mode),
    .ea         (ea),
    .wb_en_c    (wb_en_c),
    .wb_sel_c   (wb_sel_c),
    .wb_val_c   (wb_val_c),
    .ro_hit     (ro_hit),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .ro_viol    (ro_viol),
    .ptr_wb_en  (ptr_wb_en),
    .ptr_wb_sel (ptr_wb_sel),
    .ptr_wb_val (ptr_wb_val)
  );

endmodule

// File: tb/dmem_agu_test.sv
module dmem_agu_test;

  typedef struct packed {
    logic [15:0] addr;
    logic        rd;
    logic        wr;
    logic        viol;
    logic        wb_en;
    logic [1:0]  wb_sel;
    logic [15:0] wb_val;
    logic [7:0]  wdata;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_mode = '0;
  logic        req_store = 1'b0;
  logic [6:0]  req_field = '0;
  logic [1:0]  req_ptr_sel = '0;
  logic [7:0]  req_wdata = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, ro_viol, ptr_wb_en;
  logic [7:0]  mem_wdata;
  logic [1:0]  ptr_wb_sel;
  logic [15:0] ptr_wb_val;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  dmem_agu uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_store(req_store), .req_field(req_field),
    .req_ptr_sel(req_ptr_sel), .req_wdata(req_wdata),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .ro_viol(ro_viol), .ptr_wb_en(ptr_wb_en), .ptr_wb_sel(ptr_wb_sel),
    .ptr_wb_val(ptr_wb_val)
  );

  function automatic bit is_ro(input logic [15:0] a);
    return (a >= 16'h3F00 && a <= 16'h3F03) || (a >= 16'h4000 && a <= 16'h7FFF);
  endfunction

  function automatic exp_t model(input logic [1:0] m, input logic st, input logic [6:0] f,
                                 input logic [1:0] s, input logic [7:0] wd);
    exp_t e;
    logic [15:0] p;
    p = (s == 2'b00) ? ptr_x : (s == 2'b01) ? ptr_y : ptr_z;
    e = '0;
    e.wb_sel = (s == 2'b00) ? 2'd0 : (s == 2'b01) ? 2'd1 : 2'd2;
    e.wdata  = wd;
    case (m)
      2'b00: e.addr = 16'h0040 + {9'd0, f};
      2'b01: e.addr = p;
      2'b10: begin e.addr = p - 16'd1; e.wb_en = 1'b1; e.wb_val = p - 16'd1; end
      default: begin e.addr = p; e.wb_en = 1'b1; e.wb_val = p + 16'd1; end
    endcase
    e.rd   = !st;
    e.wr   = st && !is_ro(e.addr);
    e.viol = st && is_ro(e.addr);
    return e;
  endfunction

  task automatic check(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: called at a negative edge; pushes the expected access
  task automatic send(input string tag, input logic [1:0] m, input logic st, input logic [6:0] f,
                      input logic [1:0] s, input logic [7:0] wd);
    req_mode = m; req_store = st; req_field = f; req_ptr_sel = s; req_wdata = wd;
    req_valid = 1'b1;
    q.push_back(model(m, st, f, s, wd));
    tag_q.push_back(tag);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    exp_t e, a;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && (mem_rd || mem_wr || ro_viol || ptr_wb_en)) begin
        a = '{addr: mem_addr, rd: mem_rd, wr: mem_wr, viol: ro_viol, wb_en: ptr_wb_en,
              wb_sel: ptr_wb_sel, wb_val: ptr_wb_val, wdata: mem_wdata};
        if (q.size() == 0) begin
          check("R8 strobe without accepted request", 1'b0, 64'(a), 64'd0);
        end else begin
          e = q.pop_front();
          t = tag_q.pop_front();
          if (!e.wb_en) begin a.wb_sel = e.wb_sel; a.wb_val = e.wb_val; end
          check(t, a == e, 64'(a), 64'(e));
          check("R6 ready low in access cycle", req_ready == 1'b0, 64'(req_ready), 64'd0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    check("R8 reset ready", req_ready == 1'b1, 64'(req_ready), 64'd1);
    check("R8 reset strobes", {mem_rd, mem_wr, ro_viol, ptr_wb_en} == 4'b0,
          64'({mem_rd, mem_wr, ro_viol, ptr_wb_en}), 64'd0);

    ptr_x = 16'h1234; ptr_y = 16'h0100; ptr_z = 16'h00FF;
    // R1 direct window edges
    send("R1 direct field 0", 2'b00, 1'b0, 7'd0, 2'b00, 8'h11);
    send("R1 direct field 127", 2'b00, 1'b0, 7'd127, 2'b00, 8'h22);
    send("R1 direct store", 2'b00, 1'b1, 7'd5, 2'b01, 8'h33);
    // R2 indirect, each select code
    send("R2 indirect X", 2'b01, 1'b0, 7'd9, 2'b00, 8'h44);
    send("R2 indirect Y", 2'b01, 1'b1, 7'd9, 2'b01, 8'h55);
    send("R2 indirect Z code 3", 2'b01, 1'b0, 7'd9, 2'b11, 8'h66);
    // R3 / R4
    send("R3 predec Y store", 2'b10, 1'b1, 7'd0, 2'b01, 8'h77);
    send("R4 postinc Z load", 2'b11, 1'b0, 7'd0, 2'b10, 8'h88);
    // R5 wrap
    ptr_x = 16'h0000; ptr_z = 16'hFFFF;
    send("R5 predec wrap X", 2'b10, 1'b0, 7'd0, 2'b00, 8'h99);
    send("R5 postinc wrap Z", 2'b11, 1'b1, 7'd0, 2'b10, 8'hAA);
    // R7 read-only ranges and their edges
    ptr_x = 16'h3F02; ptr_y = 16'h5000; ptr_z = 16'h7FFF;
    send("R7 store lock range", 2'b01, 1'b1, 7'd0, 2'b00, 8'hBB);
    send("R7 load flash range", 2'b01, 1'b0, 7'd0, 2'b01, 8'hCC);
    send("R7 store postinc at range top", 2'b11, 1'b1, 7'd0, 2'b10, 8'hDD);
    ptr_x = 16'h4000; ptr_y = 16'h3F04; ptr_z = 16'h8000;
    send("R7 store predec below flash", 2'b10, 1'b1, 7'd0, 2'b00, 8'hEE);
    send("R7 store above lock", 2'b01, 1'b1, 7'd0, 2'b01, 8'h0F);
    send("R7 store above flash", 2'b01, 1'b1, 7'd0, 2'b10, 8'hF0);
    ptr_y = 16'h3F00;
    send("R7 predec just below lock", 2'b10, 1'b1, 7'd0, 2'b01, 8'h5A);

    // R8 idle: no strobes while nothing is offered
    repeat (6) @(negedge clk);
    check("R8 queue drained", q.size() == 0, 64'(q.size()), 64'd0);
    check("R8 idle ready", req_ready == 1'b1, 64'(req_ready), 64'd1);
    check("R8 idle strobes", {mem_rd, mem_wr, ro_viol, ptr_wb_en} == 4'b0,
          64'({mem_rd, mem_wr, ro_viol, ptr_wb_en}), 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule